// File: doc/BRIEF.md
# Scaling Texture Source Address Generator

This block produces the source address for a blitter that copies one line of texture pixels at a time and can stretch or shrink the line. A 20-bit accumulator holds the current source position as a fixed-point value. Each advance strobe adds a programmable step to it, so a step below one pixel enlarges the texture and a step above one pixel shrinks it. Bits 7..0 of the accumulator are the fraction. Bits 10..8 are a sub-byte pixel select. Bits 19..11 are the integer X byte offset within the row. A row register and an X base register sit beside the accumulator, and a carry out of bit 19 bumps the X base register.

Textures may use 1, 2, 4 or 8 bits per pixel. The select bits that a depth does not need are treated as ones while an advance is added. A carry leaving the fraction therefore skips over them and lands on the lowest select bit in use, or on the X offset when the depth is 8 bits. The shift output is the bit position of the addressed pixel inside its byte. A sequencing controller can also use the same adder for plain addition or subtraction of the step register into the accumulator. A zero flag supports its tests.

Top module: `tex_addr_gen`

## Requirements
- R1: With `rst` high at a clock edge, the accumulator, step, row and X base registers clear. After that edge `acc_o`, `addr_o` and `shift_o` read 0 and `zero_o` reads 1.
- R2: `addr_o` is {row register (upper 9 bits), X base + accumulator bits 19..11 modulo 2^12 (lower 12 bits)}. All outputs show the register state after the most recent clock edge.
- R3: With `depth` = 0 (1 bit per pixel), an advance replaces the accumulator with accumulator + step modulo 2^20, and a fraction carry enters bit 8.
- R4: With `depth` = 1 (2 bpp), accumulator bit 8 is taken as one for an advance. With `depth` = 2 (4 bpp), bits 9..8 are taken as one. A fraction carry thus reaches bit 9 or bit 10 respectively.
- R5: With `depth` = 3 (8 bpp), bits 10..8 are taken as one for an advance, so a fraction carry reaches bit 11 (X offset), and `shift_o` is 0.
- R6: `shift_o` equals accumulator bits 10..8 with the low `depth` bits cleared. That value is the pixel index within the byte times the bits per pixel, and it uses the `depth` value present at the last edge.
- R7: A carry out of bit 19 during an advance increments the X base register (modulo 2^12) at the same edge.
- R8: `ld_acc`, `ld_step`, `ld_y` and `ld_base` each load their register from `ld_data` (low bits) at the edge. An accumulator load takes priority over controller arithmetic and advance. An X base load takes priority over a carry increment.
- R9: With `alu_en` high, the accumulator becomes accumulator + step, or accumulator − step when `alu_sub` is high, modulo 2^20. No select bits are forced, and the X base register is unchanged. `alu_en` takes priority over `adv`.
- R10: `zero_o` is 1 exactly when `acc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_data | input | 20 | Shared load value for all registers |
| ld_acc | input | 1 | Load accumulator |
| ld_step | input | 1 | Load step register |
| ld_y | input | 1 | Load row register |
| ld_base | input | 1 | Load X base register |
| depth | input | 2 | Bits per pixel code: 0=1, 1=2, 2=4, 3=8 |
| adv | input | 1 | Per-pixel advance strobe |
| alu_en | input | 1 | Controller arithmetic on accumulator and step |
| alu_sub | input | 1 | Subtract instead of add when `alu_en` is high |
| addr_o | output | 21 | Texture byte address {row, X} |
| shift_o | output | 3 | Bit shift of the pixel inside the byte |
| acc_o | output | 20 | Accumulator contents |
| zero_o | output | 1 | Accumulator is zero |

## Verification
Fraction-overflow patterns (fraction 0xFF, step 1) run at each of the four depths. They separate the four carry landing points: bit 8, 9, 10 or 11. Accumulators near the top of the range with small steps drive carries out of bit 19, which show whether the X base register moves and whether a simultaneous base load wins. Subtraction down to exactly zero, and below it, checks both the flag and the wrap. A long stream of mixed loads, advances and arithmetic with random depths, compared every cycle with a behavioural model, checks the priority rules when strobes collide.

// File: rtl/tex_pkg.sv
package tex_pkg;
  // Bits-per-pixel code: texture depth is 1 << code
  typedef enum logic [1:0] {
    BPP1 = 2'd0,
    BPP2 = 2'd1,
    BPP4 = 2'd2,
    BPP8 = 2'd3
  } depth_e;

  // Operation applied to the accumulator in a cycle
  typedef enum logic [1:0] {
    ACC_HOLD  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_ALU   = 2'd2,
    ACC_STEP  = 2'd3
  } acc_op_e;
endpackage

// File: rtl/tex_depth_mask.sv
module tex_depth_mask #(
  parameter int SEL_W = 3
) (
  input  logic [1:0]       depth,
  output logic [SEL_W-1:0] force_sel,
  output logic [SEL_W-1:0] keep_sel
);
  // Select bit i is unused (forced to one) when the depth code exceeds i
  for (genvar i = 0; i < SEL_W; i++) begin : g_bit
    assign force_sel[i] = (int'(depth) > i);
    assign keep_sel[i]  = ~force_sel[i];
  end
endmodule

// File: rtl/tex_addsub.sv
module tex_addsub #(
  parameter int W = 20
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];
  assign cout  = wide[W];
endmodule

// File: rtl/tex_row_base.sv
module tex_row_base #(
  parameter int Y_W  = 9,
  parameter int XB_W = 12,
  parameter int LD_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LD_W-1:0] ld_data,
  input  logic            ld_y,
  input  logic            ld_base,
  input  logic            inc,
  output logic [Y_W-1:0]  y_q,
  output logic [Y_W-1:0]  y_next,
  output logic [XB_W-1:0] base_q,
  output logic [XB_W-1:0] base_next
);
  always_comb begin
    y_next = ld_y ? ld_data[Y_W-1:0] : y_q;
    if (ld_base)
      base_next = ld_data[XB_W-1:0];
    else if (inc)
      base_next = base_q + {{(XB_W-1){1'b0}}, 1'b1};
    else
      base_next = base_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q    <= '0;
      base_q <= '0;
    end else begin
      y_q    <= y_next;
      base_q <= base_next;
    end
  end
endmodule

// File: rtl/tex_addr_gen.sv
module tex_addr_gen #(
  parameter int FRAC_W = 8,
  parameter int SEL_W  = 3,
  parameter int XI_W   = 9,
  parameter int Y_W    = 9,
  parameter int XB_W   = 12,
  localparam int ACC_W  = FRAC_W + SEL_W + XI_W,
  localparam int LD_W   = ACC_W,
  localparam int ADDR_W = Y_W + XB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LD_W-1:0]   ld_data,
  input  logic              ld_acc,
  input  logic              ld_step,
  input  logic              ld_y,
  input  logic              ld_base,
  input  logic [1:0]        depth,
  input  logic              adv,
  input  logic              alu_en,
  input  logic              alu_sub,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEL_W-1:0]  shift_o,
  output logic [ACC_W-1:0]  acc_o,
  output logic              zero_o
);
  import tex_pkg::*;

  localparam int SEL_LO = FRAC_W;
  localparam int XI_LO  = FRAC_W + SEL_W;

  logic [ACC_W-1:0]  acc_q, acc_next, step_q, step_next;
  logic [ACC_W-1:0]  force_vec, opnd_a, add_sum;
  logic              add_cout, base_inc;
  logic [SEL_W-1:0]  force_sel, keep_sel;
  logic [Y_W-1:0]    y_q, y_next;
  logic [XB_W-1:0]   base_q, base_next, x_next;
  acc_op_e           op;

  tex_depth_mask #(.SEL_W(SEL_W)) u_mask (
    .depth     (depth),
    .force_sel (force_sel),
    .keep_sel  (keep_sel)
  );

  // Unused select bits become ones for an advance so a fraction carry skips them
  assign force_vec = {{XI_W{1'b0}}, force_sel, {FRAC_W{1'b0}}};

  always_comb begin
    if (ld_acc)      op = ACC_LOAD;
    else if (alu_en) op = ACC_ALU;
    else if (adv)    op = ACC_STEP;
    else             op = ACC_HOLD;
  end

  assign opnd_a = (op == ACC_STEP) ? (acc_q | force_vec) : acc_q;

  tex_addsub #(.W(ACC_W)) u_add (
    .a    (opnd_a),
    .b    (step_q),
    .sub  (alu_sub && (op == ACC_ALU)),
    .sum  (add_sum),
    .cout (add_cout)
  );

  always_comb begin
    unique case (op)
      ACC_LOAD: acc_next = ld_data[ACC_W-1:0];
      ACC_ALU,
      ACC_STEP: acc_next = add_sum;
      default:  acc_next = acc_q;
    endcase
    step_next = ld_step ? ld_data[ACC_W-1:0] : step_q;
  end

  assign base_inc = (op == ACC_STEP) && add_cout;

  tex_row_base #(.Y_W(Y_W), .XB_W(XB_W), .LD_W(LD_W)) u_rowbase (
    .clk       (clk),
    .rst       (rst),
    .ld_data   (ld_data),
    .ld_y      (ld_y),
    .ld_base   (ld_base),
    .inc       (base_inc),
    .y_q       (y_q),
    .y_next    (y_next),
    .base_q    (base_q),
    .base_next (base_next)
  );

  // X byte position = base + integer field of the accumulator
  generate
    if (XB_W > XI_W) begin : g_xwide
      assign x_next = base_next + {{(XB_W-XI_W){1'b0}}, acc_next[ACC_W-1:XI_LO]};
    end else begin : g_xnarrow
      assign x_next = base_next + acc_next[XI_LO+XB_W-1:XI_LO];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      step_q  <= '0;
      addr_o  <= '0;
      shift_o <= '0;
      zero_o  <= 1'b1;
    end else begin
      acc_q   <= acc_next;
      step_q  <= step_next;
      addr_o  <= {y_next, x_next};
      shift_o <= acc_next[SEL_LO+SEL_W-1:SEL_LO] & keep_sel;
      zero_o  <= (acc_next == '0);
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/tex_addr_gen_chk.sv
module tex_addr_gen_chk #(
  parameter int ACC_W  = 20,
  parameter int Y_W    = 9,
  parameter int XB_W   = 12,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic [ACC_W-1:0]  ld_data,
  input logic              ld_acc,
  input logic              ld_y,
  input logic              ld_base,
  input logic [1:0]        depth,
  input logic              adv,
  input logic              alu_en,
  input logic              carry,
  input logic [XB_W-1:0]   base_q,
  input logic [ADDR_W-1:0] addr_o,
  input logic [SEL_W-1:0]  shift_o,
  input logic [ACC_W-1:0]  acc_o,
  input logic              zero_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && addr_o == '0 && shift_o == '0 && zero_o));

  // R2
  row_field_chk: assert property (@(posedge clk) disable iff (rst)
    ld_y |=> addr_o[ADDR_W-1:XB_W] == $past(ld_data[Y_W-1:0]));

  // R4
  forced_low_chk: assert property (@(posedge clk) disable iff (rst)
    (depth == 2'd1) |=> !shift_o[0]);

  // R5
  full_byte_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (depth == 2'd3) |=> shift_o == '0);

  // R7
  base_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld_acc && !alu_en && !ld_base && carry)
      |=> base_q == XB_W'($past(base_q) + 1'b1));

  // R8
  acc_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_acc |=> acc_o == $past(ld_data));

  // R9
  alu_base_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_en && !ld_base && !ld_acc) |=> base_q == $past(base_q));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_o == (acc_o == '0));
endmodule

bind tex_addr_gen tex_addr_gen_chk #(
  .ACC_W(ACC_W), .Y_W(Y_W), .XB_W(XB_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ld_data (ld_data),
  .ld_acc  (ld_acc),
  .ld_y    (ld_y),
  .ld_base (ld_base),
  .depth   (depth),
  .adv     (adv),
  .alu_en  (alu_en),
  .carry   (add_cout),
  .base_q  (base_q),
  .addr_o  (addr_o),
  .shift_o (shift_o),
  .acc_o   (acc_o),
  .zero_o  (zero_o)
);

// File: tb/tb_tex_addr_gen.sv
module tb_tex_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] ld_data;
  logic        ld_acc, ld_step, ld_y, ld_base, adv, alu_en, alu_sub;
  logic [1:0]  depth;
  logic [20:0] addr_o;
  logic [2:0]  shift_o;
  logic [19:0] acc_o;
  logic        zero_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  longint m_acc, m_step, m_y, m_base;

  always #4 clk = ~clk;

  tex_addr_gen dut (
    .clk(clk), .rst(rst), .ld_data(ld_data), .ld_acc(ld_acc), .ld_step(ld_step),
    .ld_y(ld_y), .ld_base(ld_base), .depth(depth), .adv(adv), .alu_en(alu_en),
    .alu_sub(alu_sub), .addr_o(addr_o), .shift_o(shift_o), .acc_o(acc_o),
    .zero_o(zero_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    ld_data = '0; ld_acc = 0; ld_step = 0; ld_y = 0; ld_base = 0;
    adv = 0; alu_en = 0; alu_sub = 0;
  endtask

  function automatic longint exp_addr();
    return (m_y << 12) | ((m_base + (m_acc >> 11)) & 64'hFFF);
  endfunction

  function automatic longint exp_shift(input int d);
    longint sel = (m_acc >> 8) & 7;
    return (sel >> d) << d;
  endfunction

  // Model update from current inputs, then one edge, then compare all outputs
  task automatic tick(input string tag);
    longint s, f;
    int d = int'(depth);
    bit carry = 0;
    if (rst) begin
      m_acc = 0; m_step = 0; m_y = 0; m_base = 0;
    end else begin
      if (ld_acc) m_acc = ld_data;
      else if (alu_en) begin
        if (alu_sub) s = m_acc - m_step + 64'h100000;
        else         s = m_acc + m_step;
        m_acc = s & 64'hFFFFF;
      end else if (adv) begin
        f = m_acc | (((64'd1 << d) - 1) << 8);
        s = f + m_step;
        carry = (s >> 20) != 0;
        m_acc = s & 64'hFFFFF;
      end
      if (ld_step) m_step = ld_data;
      if (ld_y) m_y = ld_data & 64'h1FF;
      if (ld_base) m_base = ld_data & 64'hFFF;
      else if (carry) m_base = (m_base + 1) & 64'hFFF;
    end
    @(posedge clk);
    #2;
    check({tag, " acc"},   acc_o,   m_acc);
    check({tag, " addr"},  addr_o,  exp_addr());
    check({tag, " shift"}, shift_o, exp_shift(d));
    check({tag, " zero"},  zero_o,  (m_acc == 0) ? 1 : 0);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic load_all(input longint a, input longint st, input longint y, input longint b);
    ld_data = 20'(a);  ld_acc  = 1; tick("R8 ld acc");
    ld_data = 20'(st); ld_step = 1; tick("R8 ld step");
    ld_data = 20'(y);  ld_y    = 1; tick("R2 ld row");
    ld_data = 20'(b);  ld_base = 1; tick("R2 ld base");
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    depth = 2'd0;
    rst = 1;
    @(negedge clk);
    tick("R1 reset");
    check("R1 reset zero flag", zero_o, 1);
    rst = 0;
    @(negedge clk);

    // R3: 1 bpp fraction carry enters bit 8
    depth = 2'd0; load_all(64'h000FF, 1, 3, 0);
    adv = 1; tick("R3 1bpp adv");
    check("R3 acc 0x100", acc_o, 64'h00100);
    check("R6 1bpp shift", shift_o, 1);

    // R4: 2 bpp carry reaches bit 9
    depth = 2'd1; load_all(64'h000FF, 1, 3, 0);
    adv = 1; tick("R4 2bpp adv");
    check("R4 acc 0x200", acc_o, 64'h00200);
    check("R6 2bpp shift", shift_o, 2);

    // R4: 4 bpp carry reaches bit 10
    depth = 2'd2; load_all(64'h000FF, 1, 3, 0);
    adv = 1; tick("R4 4bpp adv");
    check("R4 acc 0x400", acc_o, 64'h00400);
    check("R6 4bpp shift", shift_o, 4);

    // R5: 8 bpp carry reaches the X field
    depth = 2'd3; load_all(64'h000FF, 1, 5, 64'h010);
    adv = 1; tick("R5 8bpp adv");
    check("R5 acc 0x800", acc_o, 64'h00800);
    check("R5 addr", addr_o, (64'd5 << 12) | 64'h011);
    check("R5 shift zero", shift_o, 0);

    // R7: carry out of bit 19 bumps the base
    depth = 2'd0; load_all(64'hFFFFF, 1, 7, 5);
    adv = 1; tick("R7 carry out");
    check("R7 addr", addr_o, (64'd7 << 12) | 64'd6);
    // R8: base load beats carry increment
    ld_data = 20'hFFFFF; ld_acc = 1; tick("R8 reload");
    ld_data = 20'h00009; ld_base = 1; adv = 1; tick("R8 base vs carry");
    check("R8 base load wins", addr_o & 64'hFFF, 9 + 0);

    // R9: controller add/sub, no forcing, base untouched
    depth = 2'd3; load_all(64'h00300, 64'h00300, 1, 4);
    alu_en = 1; alu_sub = 1; tick("R9 sub to zero");
    check("R10 zero after sub", zero_o, 1);
    alu_en = 1; alu_sub = 1; adv = 1; tick("R9 sub wraps");
    check("R9 wrap", acc_o, 64'hFFD00);
    alu_en = 1; tick("R9 add");
    check("R9 add back", acc_o, 64'h00000);
    check("R9 base kept", addr_o & 64'hFFF, 4);
    // R8: acc load beats alu and advance
    ld_data = 20'h12345; ld_acc = 1; alu_en = 1; adv = 1; tick("R8 acc priority");
    check("R8 acc value", acc_o, 64'h12345);

    // Mixed random stream against the reference model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      depth   = 2'($urandom_range(0, 3));
      ld_data = 20'($urandom);
      ld_acc  = (r < 6);
      ld_step = (r >= 6 && r < 12) || (r == 90);
      ld_y    = (r >= 12 && r < 16);
      ld_base = (r >= 16 && r < 20) || (r == 91);
      alu_en  = (r >= 20 && r < 28) || (r == 92);
      alu_sub = $urandom_range(0, 1) == 1;
      adv     = (r >= 28) || (r == 3);
      tick("R3 R6 R7 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule